// File: doc/BRIEF.md
# Eight-Pair Multiply-Accumulate with Carry-Save Running Sum

This block multiplies pairs of unsigned 8-bit operands and adds the products over a fixed window of eight accepted pairs. Each product comes from a parallel partial-product multiplier. A row of 3:2 compressors adds the product to a running total. The total stays in redundant form: one sum vector and one carry vector, each held in its own parallel-in parallel-out register, and both feed back into the compressor row. No carry ripples through the accumulation loop. A single carry-propagate adder on the output path merges the two vectors. The accumulator is 19 bits wide, so a window of eight full-scale products cannot overflow.

Operands enter on a valid/ready handshake. A pair is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low for exactly one cycle: the cycle in which `done` presents the window total. The upstream source must hold its pair during that cycle. At the end of that cycle the block clears itself for the next window. `result` always shows the merged running sum, and it is the window total while `done` is high. The control pins `rst` and `clr` are plain synchronous inputs.

Top module: `csa_mac_unit`

## Requirements
- R1: A synchronous `rst` or `clr` sampled high at a clock edge sets `result` to 0 and `done` to 0 after that edge, and restarts the pair count. The following window then needs eight new accepted pairs.
- R2: `in_ready` is 1 in every cycle except the cycle in which `done` is 1, where it is 0.
- R3: An accepted pair (a, b) increases `result` by exactly a*b, visible in the cycle after the accepting edge.
- R4: A clock edge with `in_valid` low leaves `result` unchanged and does not advance the pair count, whatever values `op_a` and `op_b` carry.
- R5: `done` is 1 for exactly one cycle, the cycle after the eighth accepted pair of a window. In that cycle `result` equals the sum of the eight products. `done` is 0 after the first seven pairs.
- R6: Eight pairs of 255×255 give `result` = 520200 with no overflow (19-bit unsigned result).
- R7: After the `done` cycle, `result` returns to 0 and a new window begins. A pair offered while `in_ready` is 0 is not accepted.
- R8: `clr` takes priority over `in_valid`: a pair presented at an edge with `clr` high is discarded.
- R9: Operands are unsigned, and the full 16-bit product is used, e.g. 255×255 adds 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the running sum and pair count, active high |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can accept a pair this cycle |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| result | output | 19 | Merged running sum; the window total while `done` is high |
| done | output | 1 | One-cycle flag marking the end of a window |

## Verification
A fault in either redundant register shows up at `result` in the very next cycle, because the merged output is recomputed from both vectors every cycle. The per-pair increment checks therefore catch it one edge after it occurs. A fault in the pair counter stays invisible until the window closes: `done` then arrives early or late, or `in_ready` drops in the wrong cycle. The window-length checks catch this within eight accepted pairs. A carry lost inside the compressor row shows up only for operands that create carries in high columns, which is why full-scale and mixed operands are driven.

// File: rtl/csa_mac_pkg.sv
package csa_mac_pkg;
  localparam int OPND_W  = 8;
  localparam int WINDOW  = 8;
  localparam int PROD_W  = 2 * OPND_W;
  localparam int ACCUM_W = PROD_W + $clog2(WINDOW);

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/pp_multiplier.sv
module pp_multiplier #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0] row [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign row[gi] = mcand & {W{mplier[gi]}};
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int r = 0; r < W; r++) begin
      prod = prod + (PW'(row[r]) << r);
    end
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 19
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  output logic [W-1:0] sum_v,
  output logic [W-1:0] carry_v
);
  import csa_mac_pkg::*;

  logic [W-1:0] gen;

  genvar gb;
  generate
    for (gb = 0; gb < W; gb++) begin : g_fa
      assign sum_v[gb] = in_x[gb] ^ in_y[gb] ^ in_z[gb];
      assign gen[gb]   = maj3(in_x[gb], in_y[gb], in_z[gb]);
    end
  endgenerate

  assign carry_v = {gen[W-2:0], 1'b0};
endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic restart,
  input  logic adv,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] TOP = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == TOP);
endmodule

// File: rtl/csa_mac_unit.sv
module csa_mac_unit #(
  parameter int OPND_W  = csa_mac_pkg::OPND_W,
  parameter int WINDOW  = csa_mac_pkg::WINDOW,
  parameter int ACCUM_W = 2 * OPND_W + $clog2(WINDOW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OPND_W-1:0]  op_a,
  input  logic [OPND_W-1:0]  op_b,
  output logic [ACCUM_W-1:0] result,
  output logic               done
);
  localparam int PROD_W = 2 * OPND_W;

  logic [PROD_W-1:0]  prod;
  logic [ACCUM_W-1:0] sum_q, carry_q, sum_n, carry_n;
  logic               done_q, accept, last, wipe;

  assign in_ready = ~done_q;
  assign accept   = in_valid & in_ready & ~clr & ~rst;
  assign wipe     = rst | clr;

  pp_multiplier #(.W(OPND_W)) u_mul (
    .mcand (op_a),
    .mplier(op_b),
    .prod  (prod)
  );

  csa_row #(.W(ACCUM_W)) u_csa (
    .in_x   (sum_q),
    .in_y   (carry_q),
    .in_z   (ACCUM_W'(prod)),
    .sum_v  (sum_n),
    .carry_v(carry_n)
  );

  window_counter #(.N(WINDOW)) u_cnt (
    .clk    (clk),
    .restart(wipe),
    .adv    (accept),
    .last   (last)
  );

  always_ff @(posedge clk) begin
    if (wipe || done_q) begin
      sum_q   <= '0;
      carry_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        sum_q   <= sum_n;
        carry_q <= carry_n;
      end
      done_q <= accept & last;
    end
  end

  assign result = sum_q + carry_q;
  assign done   = done_q;
endmodule

// File: rtl/csa_mac_checker.sv
module csa_mac_checker #(
  parameter int OPND_W  = 8,
  parameter int ACCUM_W = 19
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               in_valid,
  input logic               in_ready,
  input logic [OPND_W-1:0]  op_a,
  input logic [OPND_W-1:0]  op_b,
  input logic [ACCUM_W-1:0] result,
  input logic               done
);
  a_r1_wipe_zeroes: assert property (@(posedge clk)
    (rst || clr) |=> (result == '0 && !done));

  a_r2_ready_low_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  a_r3_adds_product: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !clr) |=>
      (result == $past(result) + ACCUM_W'($past(op_a)) * ACCUM_W'($past(op_b))));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr && !done) |=> $stable(result));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_restart_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (result == '0));
endmodule

bind csa_mac_unit csa_mac_checker #(.OPND_W(OPND_W), .ACCUM_W(ACCUM_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .result(result), .done(done)
);

// File: tb/csa_mac_unit_bench.sv
`timescale 1ns/1ps
module csa_mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst, clr, in_valid, in_ready, done;
  logic [7:0]  op_a, op_b;
  logic [18:0] result;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  csa_mac_unit u_csa_mac_unit (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .result(result), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int a, input int b, input bit c);
    @(negedge clk);
    in_valid = v; op_a = 8'(a); op_b = 8'(b); clr = c;
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; clr = 0; in_valid = 1; op_a = 8'd7; op_b = 8'd7;
    @(posedge clk); @(posedge clk); #5;
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset done", int'(done), 0);
    @(negedge clk); rst = 0; in_valid = 0;
    @(posedge clk); #5;
    chk("R2 ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_single();
    step(1, 255, 255, 0);
    chk("R9 full product 255x255", int'(result), 65025);
    step(1, 3, 200, 0);
    chk("R3 second product adds", int'(result), 65625);
    step(1, 50, 50, 1);
    chk("R8 clr beats valid", int'(result), 0);
    chk("R1 clr done low", int'(done), 0);
  endtask

  task automatic t_gaps();
    int exp = 0;
    for (int i = 0; i < 8; i++) begin
      int a = (i * 37 + 11) % 256;
      int b = 250 - i * 29;
      step(0, 99, 201, 0);
      chk("R4 idle edge holds", int'(result), exp);
      chk("R4 no early done", int'(done), 0);
      step(1, a, b, 0);
      exp += a * b;
      if (i < 7) begin
        chk("R3 running sum", int'(result), exp);
        chk("R5 done low before eighth", int'(done), 0);
      end
    end
    chk("R5 done on eighth", int'(done), 1);
    chk("R5 window total", int'(result), exp);
    chk("R2 ready low during done", int'(in_ready), 0);
    step(1, 9, 9, 0);
    chk("R7 cleared after done", int'(result), 0);
    chk("R5 done single cycle", int'(done), 0);
    chk("R2 ready back", int'(in_ready), 1);
    step(1, 9, 9, 0);
    chk("R7 new window first pair", int'(result), 81);
    step(0, 0, 0, 1);
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < 8; i++) step(1, 255, 255, 0);
    chk("R6 full-scale total", int'(result), 520200);
    chk("R6 done on full-scale", int'(done), 1);
    step(0, 0, 0, 0);
  endtask

  task automatic t_clear_mid();
    for (int i = 0; i < 3; i++) step(1, 4, 5, 0);
    chk("R3 partial window", int'(result), 60);
    step(0, 0, 0, 1);
    chk("R1 clear mid window", int'(result), 0);
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0);
    chk("R1 count restarted, no done at 7", int'(done), 0);
    step(1, 1, 1, 0);
    chk("R1 done after 8 fresh pairs", int'(done), 1);
    chk("R5 total of ones", int'(result), 8);
    step(0, 0, 0, 0);
  endtask

  initial begin
    rst = 1; clr = 0; in_valid = 0; op_a = 0; op_b = 0;
    t_reset();
    t_single();
    t_gaps();
    t_full_scale();
    t_clear_mid();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule